// File: doc/BRIEF.md
# Gated Hold PWM Generator

This block produces a single pulse-width-modulated drive signal for a hold stage. An up-counter advances once per prescaler tick, runs from zero up to a programmable period value and then returns to zero. The output is high from each return to zero until the counter reaches the duty value. Each period therefore lasts (period + 1) ticks, and the output is high for the first duty ticks of it.

The prescaler divides the input clock by a power of two. The division is selected by a 4-bit exponent code, which allows a wide range of output frequencies from one 8-bit counter. Duty, period and divider code sit in configuration registers. They are loaded together on a write strobe and return to fixed defaults at reset.

A hold-enable input gates generation. While it is low, the output is forced low and both counters are cleared, so each enable begins a fresh period. A new duty value is applied only at a period boundary, so the output never shows a partial cycle.

Top module: `hold_pwm_gen`

## Requirements
- R1: While running, the counter counts 0, 1, … up to the period register and then returns to 0, so one output period lasts (period + 1) prescaler ticks.
- R2: The output is high while the counter is below the active duty value. It is set when the counter wraps and cleared when the counter equals the duty value, so a duty of 0 gives a constant low output.
- R3: A duty value written in mid-period does not change the current period. It becomes active at the next wrap.
- R4: A divider code n in the range 2..15 makes one prescaler tick every 2^(n-1) clock cycles. Code 1 ticks on every clock cycle.
- R5: After reset the configuration is duty 127, period 255 and divider code 5. All three registers load from cfg_duty, cfg_period and cfg_div on a clock edge where cfg_wr is high.
- R6: With divider code 0 the counter stays at 0 and the output stays low, even with hold_en high.
- R7: When hold_en is low the output is low in the same cycle and the counter is cleared. On re-enable, the first cycle starts a fresh period at count 0.
- R8: A duty value greater than the period keeps the output high for the whole time generation is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_en | input | 1 | Enables generation. Low forces the output low and clears the counters |
| cfg_wr | input | 1 | Loads the three configuration values on this clock edge |
| cfg_duty | input | 8 | New duty value |
| cfg_period | input | 8 | New period (wrap) value |
| cfg_div | input | 4 | New divider exponent code |
| pwm_o | output | 1 | Hold PWM output |

## Verification
A wrong counter or prescaler state changes the number of high cycles per period, or the period length, within one period of the fault. The bench therefore measures the high-cycle count over exact period windows for several divider codes, periods and duties. If the active duty is taken in at the wrong moment, the period in progress when the write lands shows the wrong high count. If the counter is not cleared on disable, the first period after re-enable shows the wrong high count. A gate that does not act at once shows a high output in the same cycle that hold_en falls.

// File: rtl/hold_pwm_pkg.sv
package hold_pwm_pkg;
  localparam int CNT_W  = 8;                    // duty / period / counter width
  localparam int CODE_W = 4;                    // divider exponent code width
  localparam int PRE_W  = (1 << CODE_W) - 2;    // prescaler counter width (max divide 2^14)

  typedef struct packed {
    logic [CNT_W-1:0]  duty;
    logic [CNT_W-1:0]  period;
    logic [CODE_W-1:0] div;
  } pwm_cfg_t;
endpackage

// File: rtl/hold_pwm_cfg.sv
module hold_pwm_cfg
  import hold_pwm_pkg::*;
#(
  parameter logic [CNT_W-1:0]  DUTY_RST   = 8'd127,
  parameter logic [CNT_W-1:0]  PERIOD_RST = 8'd255,
  parameter logic [CODE_W-1:0] DIV_RST    = 4'd5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pwm_cfg_t wr_cfg,
  output pwm_cfg_t cfg_q
);
  pwm_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.duty   <= DUTY_RST;
      cfg_q.period <= PERIOD_RST;
      cfg_q.div    <= DIV_RST;
    end else begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/hold_pwm_prescale.sv
module hold_pwm_prescale
  import hold_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [PRE_W-1:0] pre_q, pre_d, limit;
  logic [PRE_W:0]   span;

  // limit = 2^(code-1) - 1 for code >= 2, else 0 (tick every cycle)
  always_comb begin
    span  = '0;
    limit = '0;
    if (code > 4'd1) begin
      span  = (PRE_W+1)'(1) << (code - 4'd1);
      limit = PRE_W'(span - (PRE_W+1)'(1));
    end
    tick  = run && (pre_q >= limit);
    pre_d = (!run || tick) ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/hold_pwm_core.sv
module hold_pwm_core
  import hold_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty_cfg,
  input  logic [CNT_W-1:0] period_cfg,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] act_duty_q,
  output logic             below_duty
);
  logic [CNT_W-1:0] cnt_d, act_duty_d;
  logic             wrap;

  always_comb begin
    wrap       = cnt_q >= period_cfg;
    cnt_d      = cnt_q;
    act_duty_d = act_duty_q;
    if (!run) begin
      cnt_d      = '0;
      act_duty_d = duty_cfg;          // idle: track the register for a fresh start
    end else if (tick) begin
      if (wrap) begin
        cnt_d      = '0;
        act_duty_d = duty_cfg;        // duty taken in only at wrap
      end else begin
        cnt_d      = cnt_q + CNT_W'(1);
      end
    end
    below_duty = cnt_q < act_duty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_duty_q <= '0;
    end else begin
      cnt_q      <= cnt_d;
      act_duty_q <= act_duty_d;
    end
  end
endmodule

// File: rtl/hold_pwm_gen.sv
module hold_pwm_gen
  import hold_pwm_pkg::*;
#(
  parameter logic [CNT_W-1:0]  DUTY_RST   = 8'd127,
  parameter logic [CNT_W-1:0]  PERIOD_RST = 8'd255,
  parameter logic [CODE_W-1:0] DIV_RST    = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_en,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_duty,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [CODE_W-1:0] cfg_div,
  output logic              pwm_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  pwm_cfg_t         wr_cfg, cfg_q;
  logic             run, tick, below_duty;
  logic [CNT_W-1:0] cnt_q, act_duty_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_cfg = '{duty: cfg_duty, period: cfg_period, div: cfg_div};

  hold_pwm_cfg #(
    .DUTY_RST  (DUTY_RST),
    .PERIOD_RST(PERIOD_RST),
    .DIV_RST   (DIV_RST)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (cfg_wr),
    .wr_cfg(wr_cfg),
    .cfg_q (cfg_q)
  );

  assign run = hold_en && (cfg_q.div != '0);

  hold_pwm_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (run),
    .code (cfg_q.div),
    .tick (tick)
  );

  hold_pwm_core u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .tick      (tick),
    .duty_cfg  (cfg_q.duty),
    .period_cfg(cfg_q.period),
    .cnt_q     (cnt_q),
    .act_duty_q(act_duty_q),
    .below_duty(below_duty)
  );

  assign pwm_o = run && below_duty;
endmodule

// File: rtl/hold_pwm_checker.sv
module hold_pwm_checker
  import hold_pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hold_en,
  input logic              run,
  input logic              tick,
  input logic [CODE_W-1:0] div_q,
  input logic [CNT_W-1:0]  period_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  act_duty_q
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q >= period_q) |=> (cnt_q == '0));                       // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q < period_q) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));  // R1

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && cnt_q >= period_q)) |=> $stable(act_duty_q));             // R3

  AST_CODE_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> (cnt_q == '0));                                            // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> (cnt_q == '0));                                                 // R7
endmodule

bind hold_pwm_gen hold_pwm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_en   (hold_en),
  .run       (run),
  .tick      (tick),
  .div_q     (cfg_q.div),
  .period_q  (cfg_q.period),
  .cnt_q     (cnt_q),
  .act_duty_q(act_duty_q)
);

// File: tb/hold_pwm_gen_test.sv
module hold_pwm_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hold_en;
  logic       cfg_wr;
  logic [7:0] cfg_duty;
  logic [7:0] cfg_period;
  logic [3:0] cfg_div;
  logic       pwm_o;

  int checks = 0;
  int fails  = 0;

  hold_pwm_gen uut (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .cfg_wr(cfg_wr),
    .cfg_duty(cfg_duty), .cfg_period(cfg_period), .cfg_div(cfg_div), .pwm_o(pwm_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  // {div[3:0], period[7:0], duty[7:0], expected high cycles[15:0]}
  localparam logic [35:0] VEC [7] = '{
    {4'd1, 8'd9, 8'd4,  16'd4 },   // R1 R2 basic
    {4'd1, 8'd9, 8'd0,  16'd0 },   // R2 duty zero
    {4'd1, 8'd9, 8'd12, 16'd10},   // R8 duty above period
    {4'd2, 8'd5, 8'd3,  16'd6 },   // R4 divide by 2
    {4'd3, 8'd3, 8'd2,  16'd8 },   // R4 divide by 4
    {4'd1, 8'd0, 8'd1,  16'd1 },   // R1 period zero
    {4'd4, 8'd7, 8'd5,  16'd40}    // R4 divide by 8
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; enables and counts high samples over n cycles
  task automatic measure(input int n, output int hi);
    hi = 0;
    hold_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      if (pwm_o) hi++;
      @(negedge clk);
    end
  endtask

  // called at a negedge with hold_en low; leaves an idle settle cycle
  task automatic load_cfg(input logic [3:0] d, input logic [7:0] p, input logic [7:0] u);
    cfg_wr = 1'b1; cfg_div = d; cfg_period = p; cfg_duty = u;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hi, hi_a, hi_b, len;
    rst_n = 1'b0; hold_en = 1'b0; cfg_wr = 1'b0;
    cfg_duty = '0; cfg_period = '0; cfg_div = '0;
    repeat (3) @(negedge clk);
    #1 check("R7 reset output low", int'(pwm_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R7 idle output low", int'(pwm_o), 0);
    @(negedge clk);

    // R5 defaults: duty 127, period 255, code 5 (16 clocks/tick)
    measure(256 * 16, hi);
    check("R5 default high count", hi, 127 * 16);
    hold_en = 1'b0;
    @(negedge clk);

    foreach (VEC[k]) begin
      load_cfg(VEC[k][35:32], VEC[k][31:24], VEC[k][23:16]);
      len = (int'(VEC[k][31:24]) + 1) << (int'(VEC[k][35:32]) - 1);
      measure(len, hi);
      check($sformatf("R1 R2 R4 R8 vector %0d", k), hi, int'(VEC[k][15:0]));
      hold_en = 1'b0;
      @(negedge clk);
    end

    // R3: duty written mid-period applies from next wrap
    load_cfg(4'd1, 8'd9, 8'd4);
    hold_en = 1'b1;
    hi_a = 0; hi_b = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (pwm_o) begin
        if (i < 10) hi_a++; else hi_b++;
      end
      if (i == 2) begin cfg_wr = 1'b1; cfg_duty = 8'd8; end
      if (i == 3) cfg_wr = 1'b0;
      @(negedge clk);
    end
    check("R3 current period keeps old duty", hi_a, 4);
    check("R3 next period uses new duty", hi_b, 8);

    // R7: drop mid-period, output low at once, fresh period after
    repeat (5) @(negedge clk);
    #1 check("R7 high before disable", int'(pwm_o), 1);
    hold_en = 1'b0;
    #1 check("R7 low same cycle", int'(pwm_o), 0);
    @(negedge clk);
    measure(10, hi);
    check("R7 fresh period after enable", hi, 8);
    hold_en = 1'b0;
    @(negedge clk);

    // R6: code 0 stops everything
    load_cfg(4'd0, 8'd9, 8'd8);
    measure(20, hi);
    check("R6 code zero output low", hi, 0);
    cfg_wr = 1'b1; cfg_div = 4'd1;
    @(negedge clk);
    cfg_wr = 1'b0;
    measure(10, hi);
    check("R6 counter held at zero", hi, 8);
    hold_en = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule